// File: doc/BRIEF.md
# Line Brownout and Protection-Latch Monitor

This block supervises a single multifunction sense input of an offline power controller. An analog front end outside the block reduces that input to three comparator flags: above 0.4 V, above 1.0 V and above 1.25 V. Two supply flags come with them: one that is high while the supply is above its turn-on level, and one that is high while the supply is below its reset level. From these five flags the block decides whether the line is in brownout, whether the external protection latch is set, and whether switching must be inhibited. All flags pass through a two-stage synchroniser before any logic uses them. All times are counted in clock cycles.

The brownout state machine (`bolm_brownout`) has three states. `BO_RUN` is normal operation. `BO_SAG` means the input is below 1.0 V and the qualification counter is running. `BO_OFF` means brownout. The transitions are: RUN→SAG when the input drops below 1.0 V. SAG→RUN when it returns above 1.0 V. SAG→OFF after `BO_CYC` cycles below 1.0 V. OFF→RUN on a supply turn-on rising edge while the input is above 1.25 V. A turn-on edge that arrives while the input is below 1.25 V leaves the block in OFF, so the input is checked again at every restart.

The latch state machine (`bolm_latch`) has five states. `LT_CLEAR` is not latched. `LT_DIP` means the input is below 0.4 V and the counter is qualifying. `LT_HELD` is latched with the input below 0.4 V. `LT_RISE` is latched while the rise from 0.4 V to 1.0 V is being timed. `LT_STUCK` is latched after a rise that was too fast. The transitions are: CLEAR→DIP on input below 0.4 V. DIP→CLEAR if the input recovers early. DIP→HELD after `LATCH_CYC` cycles. HELD→RISE on the rising crossing of 0.4 V. RISE→HELD if the input drops below 0.4 V again, which aborts the measurement. RISE→CLEAR when the input reaches 1.0 V after at least `RISE_CYC` cycles. RISE→STUCK when it reaches 1.0 V sooner. STUCK→HELD on a new drop below 0.4 V. Any state goes to CLEAR while the supply-reset flag is set.

Top module: `pin_guard_monitor`

## Requirements
- R1: `brownout` rises once the input has stayed below 1.0 V for `BO_CYC` consecutive cycles (default 270). A return above 1.0 V before then restarts the qualification.
- R2: Brownout is left only on a rising edge of `supply_on` while the input is above 1.25 V. The input level alone, held high for any time, does not release it.
- R3: While in brownout, a turn-on edge with the input below 1.25 V leaves brownout set, and the next turn-on edge checks the input again.
- R4: `latched` rises once the input has stayed below 0.4 V for `LATCH_CYC` consecutive cycles (default 210). Shorter dips do not latch.
- R5: Once latched, a rise from 0.4 V to 1.0 V that takes at least `RISE_CYC` cycles (default 450) clears the latch. A faster rise keeps it set.
- R6: While `supply_low` is high, the latch is cleared and cannot be set.
- R7: A drop back below 0.4 V during the rise aborts the timing. Time from separate rise attempts does not add up.
- R8: `sw_inhibit` is high whenever brownout or the latch is set. `inhibit_cause` is 2'b10 when latched (this takes priority), 2'b01 for brownout only, and 2'b00 otherwise.
- R9: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_gt_lo | input | 1 | Sense input above 0.4 V |
| pin_gt_mid | input | 1 | Sense input above 1.0 V |
| pin_gt_hi | input | 1 | Sense input above 1.25 V |
| supply_on | input | 1 | Supply above turn-on level |
| supply_low | input | 1 | Supply below reset level |
| brownout | output | 1 | Brownout state |
| latched | output | 1 | Protection latch state |
| sw_inhibit | output | 1 | Switching inhibited |
| inhibit_cause | output | 2 | 00 none, 01 brownout, 10 latch |

## Verification
The hardest case to reach is a latched block whose rise measurement is aborted partway through and then restarted. This only shows that the timing does not accumulate if each partial rise alone is too short while the two together would be long enough. Directed sequences build this case: two 300-cycle rises separated by a short re-dip. Random episodes combine dip lengths and rise lengths, keep every value clear of the three thresholds, and predict the latch, brownout and cause outputs from those lengths.

// File: rtl/bolm_pkg.sv
package bolm_pkg;
    typedef enum logic [1:0] {BO_RUN, BO_SAG, BO_OFF} bo_state_t;
    typedef enum logic [2:0] {LT_CLEAR, LT_DIP, LT_HELD, LT_RISE, LT_STUCK} lt_state_t;
    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_BROWNOUT = 2'b01,
        CAUSE_LATCH    = 2'b10
    } cause_t;
endpackage

// File: rtl/bolm_sync.sv
module bolm_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/bolm_brownout.sv
module bolm_brownout
    import bolm_pkg::*;
#(
    parameter int BO_CYC = 270
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mid_s,
    input  logic hi_s,
    input  logic turn_on_evt,
    output logic brownout
);
    localparam int CW = $clog2(BO_CYC + 1);

    bo_state_t        state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            BO_RUN: begin
                if (!mid_s) state_d = BO_SAG;
            end
            BO_SAG: begin
                if (mid_s)                           state_d = BO_RUN;
                else if (cnt_q == CW'(BO_CYC - 1))   state_d = BO_OFF;
                else                                 cnt_d   = cnt_q + 1'b1;
            end
            BO_OFF: begin
                if (turn_on_evt && hi_s) state_d = BO_RUN;
            end
            default: state_d = BO_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BO_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        brownout = (state_q == BO_OFF);
    end

    AST_BO_ENTRY_NEEDS_SAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brownout) |-> $past(!mid_s)); // R1
    AST_BO_RELEASE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brownout) |-> $past(turn_on_evt && hi_s)); // R2
    AST_BO_HOLD_LOW_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (brownout && !hi_s) |=> brownout); // R3
endmodule

// File: rtl/bolm_latch.sv
module bolm_latch
    import bolm_pkg::*;
#(
    parameter int LATCH_CYC = 210,
    parameter int RISE_CYC  = 450
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_s,
    input  logic mid_s,
    input  logic rst_s,
    output logic latched
);
    localparam int MAXC = (LATCH_CYC > RISE_CYC) ? LATCH_CYC : RISE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    lt_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        if (rst_s) begin
            state_d = LT_CLEAR;
        end else begin
            unique case (state_q)
                LT_CLEAR: begin
                    if (!lo_s) state_d = LT_DIP;
                end
                LT_DIP: begin
                    if (lo_s)                              state_d = LT_CLEAR;
                    else if (cnt_q == CW'(LATCH_CYC - 1))  state_d = LT_HELD;
                    else                                   cnt_d   = cnt_q + 1'b1;
                end
                LT_HELD: begin
                    if (lo_s) state_d = LT_RISE;
                end
                LT_RISE: begin
                    if (!lo_s) begin
                        state_d = LT_HELD;
                    end else if (mid_s) begin
                        state_d = (cnt_q >= CW'(RISE_CYC)) ? LT_CLEAR : LT_STUCK;
                    end else begin
                        cnt_d = (cnt_q < CW'(RISE_CYC)) ? cnt_q + 1'b1 : cnt_q;
                    end
                end
                LT_STUCK: begin
                    if (!lo_s) state_d = LT_HELD;
                end
                default: state_d = LT_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LT_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LT_HELD, LT_RISE, LT_STUCK: latched = 1'b1;
            default:                    latched = 1'b0;
        endcase
    end

    AST_LATCH_NEEDS_DIP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(!lo_s)); // R4
    AST_CLEAR_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latched) |-> ($past(mid_s) || $past(rst_s))); // R5
    AST_SUPPLY_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_s |=> !latched); // R6
    AST_REDIP_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !lo_s && !rst_s) |=> latched); // R7
endmodule

// File: rtl/pin_guard_monitor.sv
module pin_guard_monitor
    import bolm_pkg::*;
#(
    parameter int BO_CYC      = 270,
    parameter int LATCH_CYC   = 210,
    parameter int RISE_CYC    = 450,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_gt_lo,
    input  logic       pin_gt_mid,
    input  logic       pin_gt_hi,
    input  logic       supply_on,
    input  logic       supply_low,
    output logic       brownout,
    output logic       latched,
    output logic       sw_inhibit,
    output logic [1:0] inhibit_cause
);
    localparam int NFLAG = 5;

    logic [NFLAG-1:0] raw_flags, sync_flags;
    logic lo_s, mid_s, hi_s, on_s, low_s;
    logic on_q, turn_on_evt;
    cause_t cause;

    assign raw_flags = {supply_low, supply_on, pin_gt_hi, pin_gt_mid, pin_gt_lo};

    bolm_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_flags),
        .dout (sync_flags)
    );

    assign {low_s, on_s, hi_s, mid_s, lo_s} = sync_flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= on_s;
    end
    assign turn_on_evt = on_s & ~on_q;

    bolm_brownout #(.BO_CYC(BO_CYC)) u_bo (
        .clk        (clk),
        .rst_n      (rst_n),
        .mid_s      (mid_s),
        .hi_s       (hi_s),
        .turn_on_evt(turn_on_evt),
        .brownout   (brownout)
    );

    bolm_latch #(.LATCH_CYC(LATCH_CYC), .RISE_CYC(RISE_CYC)) u_lt (
        .clk    (clk),
        .rst_n  (rst_n),
        .lo_s   (lo_s),
        .mid_s  (mid_s),
        .rst_s  (low_s),
        .latched(latched)
    );

    always_comb begin
        if (latched)       cause = CAUSE_LATCH;
        else if (brownout) cause = CAUSE_BROWNOUT;
        else               cause = CAUSE_NONE;
        inhibit_cause = cause;
        sw_inhibit    = (cause != CAUSE_NONE);
    end

    AST_CAUSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inhibit_cause)); // R8
    AST_INHIBIT_WITH_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (brownout || latched) |-> sw_inhibit); // R8
endmodule

// File: tb/pin_guard_monitor_test.sv
module pin_guard_monitor_test;
    localparam int BO  = 270;
    localparam int LAT = 210;
    localparam int RIS = 450;
    localparam int GAP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lo = 1'b1, mid = 1'b1, hi = 1'b1, son = 1'b1, slow = 1'b0;
    logic bo, lt, inh;
    logic [1:0] cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_guard_monitor uut (
        .clk(clk), .rst_n(rst_n),
        .pin_gt_lo(lo), .pin_gt_mid(mid), .pin_gt_hi(hi),
        .supply_on(son), .supply_low(slow),
        .brownout(bo), .latched(lt), .sw_inhibit(inh), .inhibit_cause(cause)
    );

    function automatic logic [1:0] exp_cause(input bit l, input bit b);
        return l ? 2'b10 : (b ? 2'b01 : 2'b00);
    endfunction

    function automatic bit exp_latch(input int d, input int r);
        return (d > LAT) && (r < RIS);
    endfunction

    function automatic bit exp_bo(input int d, input int r);
        return (d + r) > BO;
    endfunction

    function automatic bit near(input int v, input int t);
        return (v >= t - GAP) && (v <= t + GAP);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_pin(input int mv);
        @(negedge clk);
        lo  = (mv > 400);
        mid = (mv > 1000);
        hi  = (mv > 1250);
    endtask

    task automatic restart_supply();
        @(negedge clk); son = 1'b0;
        wait_cyc(4);
        son = 1'b1;
        wait_cyc(6);
    endtask

    task automatic supply_reset();
        @(negedge clk); slow = 1'b1;
        wait_cyc(4);
        slow = 1'b0;
        wait_cyc(4);
    endtask

    task automatic profile(input int d, input int r);
        set_pin(200);
        wait_cyc(d);
        if (r > 0) begin
            set_pin(700);
            wait_cyc(r);
        end
        set_pin(2000);
        wait_cyc(8);
    endtask

    task automatic cleanup();
        supply_reset();
        restart_supply();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int d, r;
        void'($urandom(32'd4242));
        wait_cyc(3);
        // R9 reset state
        chk("R9 brownout", bo, 0);
        chk("R9 latched", lt, 0);
        chk("R9 inhibit", inh, 0);
        chk("R9 cause", cause, 0);
        rst_n = 1'b1;
        wait_cyc(5);

        // R4 short dip, no latch
        profile(150, 0);
        chk("R4 short dip latched", lt, 0);
        chk("R4 short dip inhibit", inh, 0);

        // R1 sag below 1.0 V but above 0.4 V
        set_pin(700); wait_cyc(BO - 40); set_pin(2000); wait_cyc(6);
        chk("R1 short sag", bo, 0);
        set_pin(700); wait_cyc(BO + 30);
        chk("R1 brownout", bo, 1);
        chk("R8 cause brownout", cause, 2'b01);
        chk("R1 no latch", lt, 0);
        // R2 pin level alone does not release
        set_pin(2000); wait_cyc(60);
        chk("R2 level only", bo, 1);
        // R3 turn-on with pin between 1.0 and 1.25 V
        set_pin(1100); wait_cyc(4);
        restart_supply();
        chk("R3 recheck low", bo, 1);
        set_pin(2000); wait_cyc(4);
        restart_supply();
        chk("R2 release", bo, 0);
        chk("R8 cause none", cause, 0);

        // R8 priority: latch and brownout together
        profile(300, 0);
        chk("R8 latched", lt, 1);
        chk("R8 brownout", bo, 1);
        chk("R8 cause latch", cause, 2'b10);
        chk("R8 inhibit", inh, 1);
        // R6 supply reset clears latch only
        supply_reset();
        chk("R6 latch cleared", lt, 0);
        chk("R6 cause brownout", cause, 2'b01);
        restart_supply();

        // R5 fast rise keeps latch
        profile(250, 300);
        chk("R5 300 keeps", lt, 1);
        // R5 slow rise clears
        profile(30, 560);
        chk("R5 560 clears", lt, 0);
        cleanup();

        // R7 abort then retry
        profile(250, 0);
        set_pin(200); wait_cyc(10);
        set_pin(700); wait_cyc(300);
        set_pin(200); wait_cyc(40);
        set_pin(700); wait_cyc(300);
        set_pin(2000); wait_cyc(8);
        chk("R7 no accumulation", lt, 1);
        cleanup();

        // R6 held supply reset blocks latching
        @(negedge clk); slow = 1'b1;
        profile(300, 0);
        chk("R6 hold blocks latch", lt, 0);
        @(negedge clk); slow = 1'b0;
        wait_cyc(4);
        restart_supply();

        // random episodes
        for (int e = 0; e < 40; e++) begin
            do begin
                d = 20 + int'($urandom_range(380));
                r = int'($urandom_range(700));
            end while (near(d, LAT) || near(r, RIS) || near(d + r, BO));
            profile(d, r);
            chk("R4 R5 random latch", lt, exp_latch(d, r));
            chk("R1 random brownout", bo, exp_bo(d, r));
            chk("R8 random cause", cause, exp_cause(exp_latch(d, r), exp_bo(d, r)));
            cleanup();
            chk("R2 R6 random clean", inh, 0);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule